// File: doc/BRIEF.md
# Load-Use Interlock and Branch Squash Controller

This block decides, every cycle, whether a five-stage in-order pipeline advances, holds or discards work. It looks at the instruction sitting between fetch and decode (its two source register numbers, whether each source is really read, and its class) and at the instruction between decode and execute (whether it is a load and which register it writes). It also sees a taken flag from the branch unit in the execute stage. Its outputs are purely combinational strobes: a program-counter write enable and target select, a write enable and a flush for the fetch/decode register, and a bubble insert and a flush for the decode/execute register.

A one-cycle interlock is raised only when a load in execute is followed by an instruction that needs the loaded value when it enters execute. A store that depends on the load only through the data it writes to memory does not stall, because that value is needed one stage later. Branches are predicted not taken; when one resolves taken, the two younger wrong-path instructions are discarded and the program counter takes the branch target. A taken branch wins over an interlock in the same cycle.

Top module: `hzd_unit`

## Requirements
- R1: While rstN is low the strobes are idle: pcWrEn=1, fdWrEn=1, pcSelTarget=0, fdFlush=0, dxBubble=0, dxFlush=0.
- R2: When exIsLoad=1, exRd is non-zero, decRs1Used=1 and decRs1 equals exRd (any decKind), and no branch is taken, the block stalls: pcWrEn=0, fdWrEn=0, dxBubble=1, pcSelTarget=0, fdFlush=0, dxFlush=0.
- R3: When exIsLoad=1, exRd is non-zero, decRs2Used=1, decRs2 equals exRd and decKind is not store, the same stall as R2 is raised. decKind encoding: 0 = ALU, 1 = load, 2 = store, 3 = branch.
- R4: A store (decKind=2) whose only match against the loaded register is decRs2 does not stall.
- R5: A load whose destination exRd is register 0 never causes a stall.
- R6: When exIsLoad=0 no stall is raised, whatever the register fields.
- R7: A source whose used flag is 0 never causes a stall, even if its number equals exRd.
- R8: When exBranchTaken=1: pcWrEn=1, pcSelTarget=1, fdWrEn=1, fdFlush=1, dxFlush=1, dxBubble=0.
- R9: When a taken branch and a load-use stall condition occur in the same cycle, the R8 outputs are produced and the stall is suppressed.
- R10: With no stall and no taken branch, fetch continues sequentially: pcWrEn=1, fdWrEn=1, all other strobes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded assertions only |
| rstN | input | 1 | Active-low reset; forces idle strobes |
| decRs1 | input | REG_W | First source register of the fetch/decode instruction |
| decRs2 | input | REG_W | Second source register of the fetch/decode instruction |
| decRs1Used | input | 1 | First source is actually read |
| decRs2Used | input | 1 | Second source is actually read |
| decKind | input | 2 | Class of the fetch/decode instruction (0 ALU, 1 load, 2 store, 3 branch) |
| exIsLoad | input | 1 | Decode/execute instruction is a load |
| exRd | input | REG_W | Destination register of the decode/execute instruction |
| exBranchTaken | input | 1 | Branch in execute resolved taken |
| pcWrEn | output | 1 | Program counter update enable |
| pcSelTarget | output | 1 | Program counter loads the branch target instead of the sequential address |
| fdWrEn | output | 1 | Fetch/decode register write enable |
| fdFlush | output | 1 | Fetch/decode register loads a no-op |
| dxBubble | output | 1 | Decode/execute register loads a no-op because of an interlock |
| dxFlush | output | 1 | Decode/execute register loads a no-op because of a taken branch |

## Verification
The assertions watch on every cycle that an interlock always freezes both the program counter and the fetch/decode register, that a taken branch always produces both flushes and suppresses the bubble, and that a zero destination, a non-load in execute, or two unused sources never yield a bubble. Whether the exact stall decision is right for every combination of register numbers, used flags and instruction class, including the store data exemption, can only be shown by the bench's sweep, which compares all six strobes against values it computes itself for every combination of a reduced register file.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } instKind_e;

  // Strobes from the control to the pipeline registers and program counter
  typedef struct packed {
    logic pcWrEn;
    logic pcSelTarget;
    logic fdWrEn;
    logic fdFlush;
    logic dxBubble;
    logic dxFlush;
  } pipeStrobe_t;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_BASE = 0;   // index of the address source
  localparam int unsigned SRC_DATA = 1;   // index of the second source

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_W-1:0] srcAddr,
  input  logic [NUM_SRC-1:0]       srcUsed,
  input  logic                     dstIsLoad,
  input  logic [REG_W-1:0]         dstAddr,
  output logic [NUM_SRC-1:0]       srcHit
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dstLive;
  assign dstLive = dstIsLoad && (dstAddr != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [REG_W-1:0] thisAddr;
    assign thisAddr  = srcAddr[g*REG_W +: REG_W];
    assign srcHit[g] = dstLive && srcUsed[g] && (thisAddr == dstAddr);
  end

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  instKind_e         decKind,
  input  logic [NUM_SRC-1:0] srcHit,
  input  logic              branchTaken,
  output pipeStrobe_t       strobe
);

  // Sources needed on entry to execute; a store's data source is used later
  logic [NUM_SRC-1:0] execNeed;
  always_comb begin
    execNeed = '1;
    if (decKind == KIND_STORE) execNeed[SRC_DATA] = 1'b0;
  end

  logic useStall;
  assign useStall = |(srcHit & execNeed);

  always_comb begin
    strobe = '{pcWrEn: 1'b1, pcSelTarget: 1'b0, fdWrEn: 1'b1,
               fdFlush: 1'b0, dxBubble: 1'b0, dxFlush: 1'b0};
    if (rstN) begin
      if (branchTaken) begin
        strobe.pcSelTarget = 1'b1;
        strobe.fdFlush     = 1'b1;
        strobe.dxFlush     = 1'b1;
      end else if (useStall) begin
        strobe.pcWrEn   = 1'b0;
        strobe.fdWrEn   = 1'b0;
        strobe.dxBubble = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p_idle_reset_r1: assert (strobe.pcWrEn && strobe.fdWrEn && !strobe.pcSelTarget
                               && !strobe.fdFlush && !strobe.dxBubble && !strobe.dxFlush)
        else $error("reset strobes not idle");
    end
  end

  p_stall_freeze_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dxBubble |-> (!strobe.pcWrEn && !strobe.fdWrEn && !strobe.fdFlush));

  p_store_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decKind == KIND_STORE && !srcHit[SRC_BASE]) |-> !strobe.dxBubble);

  p_flush_prio_r9: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (strobe.fdFlush && strobe.dxFlush && !strobe.dxBubble
                     && strobe.pcWrEn && strobe.pcSelTarget));

  p_no_hit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (srcHit == '0 && !branchTaken) |-> (strobe.pcWrEn && strobe.fdWrEn && !strobe.dxBubble));

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] decRs1,
  input  logic [REG_W-1:0] decRs2,
  input  logic             decRs1Used,
  input  logic             decRs2Used,
  input  logic [1:0]       decKind,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] exRd,
  input  logic             exBranchTaken,
  output logic             pcWrEn,
  output logic             pcSelTarget,
  output logic             fdWrEn,
  output logic             fdFlush,
  output logic             dxBubble,
  output logic             dxFlush
);

  logic [NUM_SRC-1:0] srcHit;
  pipeStrobe_t        strobe;

  hzd_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) uMatch (
    .srcAddr   ({decRs2, decRs1}),
    .srcUsed   ({decRs2Used, decRs1Used}),
    .dstIsLoad (exIsLoad),
    .dstAddr   (exRd),
    .srcHit    (srcHit)
  );

  hzd_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .decKind     (instKind_e'(decKind)),
    .srcHit      (srcHit),
    .branchTaken (exBranchTaken),
    .strobe      (strobe)
  );

  assign pcWrEn      = strobe.pcWrEn;
  assign pcSelTarget = strobe.pcSelTarget;
  assign fdWrEn      = strobe.fdWrEn;
  assign fdFlush     = strobe.fdFlush;
  assign dxBubble    = strobe.dxBubble;
  assign dxFlush     = strobe.dxFlush;

  p_zero_dest_r5: assert property (@(posedge clk) disable iff (!rstN)
    (exRd == '0) |-> !dxBubble);

  p_no_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    !exIsLoad |-> !dxBubble);

  p_unused_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!decRs1Used && !decRs2Used) |-> !dxBubble);

endmodule

// File: tb/sim_hzd_unit.sv
module sim_hzd_unit;

  localparam int unsigned RW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [RW-1:0] decRs1 = '0, decRs2 = '0, exRd = '0;
  logic          decRs1Used = 1'b0, decRs2Used = 1'b0;
  logic [1:0]    decKind = 2'd0;
  logic          exIsLoad = 1'b0, exBranchTaken = 1'b0;
  logic          pcWrEn, pcSelTarget, fdWrEn, fdFlush, dxBubble, dxFlush;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  hzd_unit #(.REG_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .decRs1(decRs1), .decRs2(decRs2),
    .decRs1Used(decRs1Used), .decRs2Used(decRs2Used), .decKind(decKind),
    .exIsLoad(exIsLoad), .exRd(exRd), .exBranchTaken(exBranchTaken),
    .pcWrEn(pcWrEn), .pcSelTarget(pcSelTarget), .fdWrEn(fdWrEn),
    .fdFlush(fdFlush), .dxBubble(dxBubble), .dxFlush(dxFlush)
  );

  // order: pcWrEn pcSelTarget fdWrEn fdFlush dxBubble dxFlush
  localparam logic [5:0] EXP_RUN   = 6'b101000;
  localparam logic [5:0] EXP_STALL = 6'b000010;
  localparam logic [5:0] EXP_TAKEN = 6'b111101;

  task automatic check(input string tag, input logic [5:0] expv);
    logic [5:0] act;
    act = {pcWrEn, pcSelTarget, fdWrEn, fdFlush, dxBubble, dxFlush};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s rs1=%0d/%0b rs2=%0d/%0b kind=%0d ld=%0b rd=%0d tk=%0b act=%b exp=%b",
               tag, decRs1, decRs1Used, decRs2, decRs2Used, decKind, exIsLoad, exRd,
               exBranchTaken, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state with a stall pattern and a taken branch on the inputs
    @(negedge clk);
    exIsLoad = 1'b1; exRd = 3'd2; decRs1 = 3'd2; decRs1Used = 1'b1;
    #5 check("R1 stall pattern in reset", EXP_RUN);
    @(negedge clk);
    exBranchTaken = 1'b1;
    #5 check("R1 taken in reset", EXP_RUN);
    @(negedge clk);
    rstN = 1'b1;
    exBranchTaken = 1'b0; exIsLoad = 1'b0;
    @(negedge clk);

    for (int tk = 0; tk < 2; tk++)
      for (int ld = 0; ld < 2; ld++)
        for (int kd = 0; kd < 4; kd++)
          for (int us = 0; us < 4; us++)
            for (int rd = 0; rd < (1 << RW); rd++)
              for (int a = 0; a < (1 << RW); a++)
                for (int b = 0; b < (1 << RW); b++) begin
                  bit m1, m2, h1, h2, stall;
                  string tag;
                  logic [5:0] expv;
                  @(negedge clk);
                  exBranchTaken = tk[0]; exIsLoad = ld[0]; decKind = kd[1:0];
                  decRs1Used = us[0]; decRs2Used = us[1];
                  exRd = rd[RW-1:0]; decRs1 = a[RW-1:0]; decRs2 = b[RW-1:0];
                  m1 = (a == rd); m2 = (b == rd);
                  h1 = ld[0] && rd != 0 && us[0] && m1;
                  h2 = ld[0] && rd != 0 && us[1] && m2 && kd != 2;
                  stall = h1 || h2;
                  if (tk != 0) begin
                    expv = EXP_TAKEN;
                    tag = stall ? "R9 flush over stall" : "R8 taken flush";
                  end else if (stall) begin
                    expv = EXP_STALL;
                    tag = h1 ? "R2 rs1 load-use" : "R3 rs2 load-use";
                  end else begin
                    expv = EXP_RUN;
                    if (ld == 0) tag = "R6 no load";
                    else if (rd == 0 && ((us[0] && m1) || (us[1] && m2))) tag = "R5 zero dest";
                    else if (kd == 2 && us[1] && m2) tag = "R4 store data only";
                    else if ((!us[0] && m1) || (!us[1] && m2)) tag = "R7 unused source";
                    else tag = "R10 sequential";
                  end
                  #5 check(tag, expv);
                end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule